// File: doc/BRIEF.md
# Looping Melody Sequencer

This block plays a fixed tune by itself. A constant table of 29 note codes sits inside it. Each code is held for the same number of system clock cycles, and then the block moves on to the next code. After the last entry the index returns to the first, so the tune repeats for as long as the block is enabled. The note code output goes straight to the note input of a tone generator, which sits outside this block. Code 0 asks that generator for silence.

One enable input gates the whole sequencer. While it is low, time stands still: the hold counter, the table index and the output code all keep their values. When it goes high again, the count picks up from where it stopped. The hold length is the parameter `HOLD_CYCLES`. A note lasts `HOLD_CYCLES + 1` enabled clock edges. The default gives about half a second at 100 MHz, and a bench can set it to a few cycles.

Top module: `melody_seq`

## Requirements
- R1: While `rst_ni` is low, `note_o` is 0 (silence), and the hold counter and table index are cleared. The first note after reset is therefore table entry 0.
- R2: While `en_i` is high, `note_o` is registered and changes only on the clock edge at which the hold counter equals `HOLD_CYCLES`. Loads are therefore exactly `HOLD_CYCLES + 1` enabled edges apart.
- R3: After reset, `note_o` stays 0 for the first `HOLD_CYCLES` enabled edges. On the next enabled edge it takes the value of entry 0.
- R4: Entries play in index order. Each code is the number of semitones above B3, so 8 is G4 and 13 is C5. The table, from index 0 to 28, is: 8,8,10,8,13,12, 8,8,10,8,15,13, 8,8,20,17,13,12,10, 18,18,17,13,15,13, 13,13,12,13.
- R5: The load that uses entry 28 is followed, one period later, by entry 0 again, so the tune repeats without a gap.
- R6: While `en_i` is low, `note_o`, the hold counter and the index keep their values. After `en_i` returns high, the note that is playing finishes only its remaining count.
- R7: Every table entry is non-zero, so `note_o` is never 0 after the first load unless reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Play enable; low freezes the sequencer |
| note_o | output | 5 | Current note code to the tone generator, 0 = silence |

## Verification
A wrong count shows up as a note edge that comes early or late against the `HOLD_CYCLES + 1` rhythm, within one note period. A wrong index shows up as the wrong code at the next load. A wrap fault, where the index skips an entry or runs past 28, can only show once the whole tune has played, so the bench runs the table through its end and into a second pass. A leak through the enable gate shows up as a changed code or a shortened remaining note as soon as `en_i` returns high.

// File: rtl/melody_pkg.sv
// melody_pkg: widths and the constant tune shared by the sequencer.
// Assumes the tone generator decodes code k (k > 0) as k semitones above B3
// and code 0 as silence.
package melody_pkg;

    localparam int SONG_LEN = 29;
    localparam int IDX_W    = $clog2(SONG_LEN);
    localparam int CODE_W   = 5;

    typedef logic [CODE_W-1:0] note_code_t;
    typedef logic [IDX_W-1:0]  song_idx_t;

    // Returns the note code stored at table position i; 0 outside the table.
    function automatic note_code_t song_entry(song_idx_t i);
        note_code_t c;
        case (i)
            5'd0:  c = 5'd8;
            5'd1:  c = 5'd8;
            5'd2:  c = 5'd10;
            5'd3:  c = 5'd8;
            5'd4:  c = 5'd13;
            5'd5:  c = 5'd12;
            5'd6:  c = 5'd8;
            5'd7:  c = 5'd8;
            5'd8:  c = 5'd10;
            5'd9:  c = 5'd8;
            5'd10: c = 5'd15;
            5'd11: c = 5'd13;
            5'd12: c = 5'd8;
            5'd13: c = 5'd8;
            5'd14: c = 5'd20;
            5'd15: c = 5'd17;
            5'd16: c = 5'd13;
            5'd17: c = 5'd12;
            5'd18: c = 5'd10;
            5'd19: c = 5'd18;
            5'd20: c = 5'd18;
            5'd21: c = 5'd17;
            5'd22: c = 5'd13;
            5'd23: c = 5'd15;
            5'd24: c = 5'd13;
            5'd25: c = 5'd13;
            5'd26: c = 5'd13;
            5'd27: c = 5'd12;
            5'd28: c = 5'd13;
            default: c = 5'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/melody_hold_timer.sv
// melody_hold_timer: counts enabled clock edges and flags the edge on which
// the current note has been held long enough. Assumes HOLD_CYCLES >= 1.
module melody_hold_timer #(
    parameter int HOLD_CYCLES = 50_000_000,
    localparam int CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic             step_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Step fires on an enabled edge once the count has reached the limit.
    assign step_o = en_i && (cnt_q == LIMIT);
    assign cnt_o  = cnt_q;

    // Advance the hold count while enabled, restarting it at each step.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/melody_index_ctr.sv
// melody_index_ctr: table position that advances by one on each step and
// wraps from the last entry back to zero. Assumes LEN >= 2.
module melody_index_ctr #(
    parameter int  LEN   = 29,
    localparam int IDX_W = $clog2(LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

    logic [IDX_W-1:0] idx_q;

    assign idx_o = idx_q;

    // Move to the next entry on a step, wrapping after the last one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (step_i) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/melody_note_rom.sv
// melody_note_rom: combinational lookup of the tune table. Assumes the
// index stays below melody_pkg::SONG_LEN.
module melody_note_rom
    import melody_pkg::*;
(
    input  song_idx_t  idx_i,
    output note_code_t code_o
);

    // Look up the code for the addressed table position.
    always_comb begin
        code_o = song_entry(idx_i);
    end

endmodule

// File: rtl/melody_seq.sv
// melody_seq: steps through the constant tune, holding each note for
// HOLD_CYCLES+1 enabled clocks and looping at the end of the table.
// Assumes a synchronous active-low reset and an enable that is already
// synchronised to clk_i.
module melody_seq
    import melody_pkg::*;
#(
    parameter int  HOLD_CYCLES = 50_000_000,
    localparam int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    output logic [CODE_W-1:0] note_o
);

    logic             step;
    logic [CNT_W-1:0] cnt_q;
    song_idx_t        idx_q;
    note_code_t       rom_code;
    note_code_t       note_q;

    melody_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .step_o (step),
        .cnt_o  (cnt_q)
    );

    melody_index_ctr #(
        .LEN (SONG_LEN)
    ) u_index (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step),
        .idx_o  (idx_q)
    );

    melody_note_rom u_rom (
        .idx_i  (idx_q),
        .code_o (rom_code)
    );

    // Capture the addressed table entry when the hold period ends.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            note_q <= '0;
        end else if (step) begin
            note_q <= rom_code;
        end
    end

    assign note_o = note_q;

endmodule

// File: rtl/melody_seq_chk.sv
// melody_seq_chk: temporal checks on the sequencer, attached to every
// melody_seq instance by the bind below.
module melody_seq_chk #(
    parameter int HOLD_CYCLES = 50_000_000,
    parameter int SONG_LEN    = 29,
    parameter int CNT_W       = 26,
    parameter int IDX_W       = 5,
    parameter int CODE_W      = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              step,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [IDX_W-1:0]  idx_q,
    input logic [CODE_W-1:0] note_o
);

    // R2
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cnt_q) <= HOLD_CYCLES);

    // R2
    cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step |=> (cnt_q == '0));

    // R2
    note_only_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step |=> $stable(note_o));

    // R5
    idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(idx_q) < SONG_LEN);

    // R5
    idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && int'(idx_q) == SONG_LEN - 1) |=> (idx_q == '0));

    // R6
    frozen_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(note_o) && $stable(cnt_q) && $stable(idx_q)));

    // R7
    loaded_note_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step |=> (note_o != '0));

endmodule

bind melody_seq melody_seq_chk #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .SONG_LEN    (melody_pkg::SONG_LEN),
    .CNT_W       (CNT_W),
    .IDX_W       (melody_pkg::IDX_W),
    .CODE_W      (melody_pkg::CODE_W)
) u_melody_seq_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step   (step),
    .cnt_q  (cnt_q),
    .idx_q  (idx_q),
    .note_o (note_o)
);

// File: tb/melody_seq_bench.sv
// melody_seq_bench: directed scenarios against a shortened hold period.
module melody_seq_bench;

    localparam int HOLD = 3;
    localparam int PER  = HOLD + 1;
    localparam int LEN  = 29;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       en_i = 1'b0;
    logic [4:0] note_o;

    int total = 0;
    int bad   = 0;

    int tune [LEN] = '{8, 8, 10, 8, 13, 12, 8, 8, 10, 8, 15, 13,
                       8, 8, 20, 17, 13, 12, 10, 18, 18, 17, 13, 15, 13,
                       13, 13, 12, 13};

    always #2.5 clk_i = ~clk_i;

    melody_seq #(.HOLD_CYCLES(HOLD)) u_melody_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .note_o (note_o)
    );

    // Advance n clock periods, landing on a falling edge.
    task automatic tick(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic check(input string req, input int exp);
        total++;
        if (int'(note_o) != exp) begin
            bad++;
            $display("FAIL %s note_o actual=%0d expected=%0d", req, note_o, exp);
        end
    endtask

    // R1: output silent during and right after reset.
    task automatic t_reset();
        rst_ni = 1'b0;
        en_i   = 1'b0;
        tick(3);
        check("R1", 0);
        rst_ni = 1'b1;
        tick(2);
        check("R1", 0);
    endtask

    // R3: first note appears exactly one period after enabling.
    task automatic t_first_note();
        en_i = 1'b1;
        tick(HOLD);
        check("R3", 0);
        tick(1);
        check("R3", tune[0]);
    endtask

    // R6: disabled mid-note, the remaining count resumes afterwards.
    task automatic t_pause();
        tick(2);
        en_i = 1'b0;
        tick(10);
        check("R6", tune[0]);
        en_i = 1'b1;
        tick(PER - 3);
        check("R6", tune[0]);
        tick(1);
        check("R6", tune[1]);
    endtask

    // R2 R4 R5 R7: walk the rest of the table and into the second pass.
    task automatic t_loop();
        for (int k = 2; k < LEN + 3; k++) begin
            tick(PER - 1);
            check("R2", tune[(k - 1) % LEN]);
            tick(1);
            if (k >= LEN) check("R5", tune[k % LEN]);
            else          check("R4", tune[k]);
            if (note_o == 5'd0) begin
                total++;
                bad++;
                $display("FAIL R7 note_o actual=0 expected=nonzero");
            end
        end
    endtask

    // R1: reset in the middle of the tune restarts it from entry 0.
    task automatic t_reset_mid();
        tick(2);
        rst_ni = 1'b0;
        tick(1);
        check("R1", 0);
        rst_ni = 1'b1;
        tick(HOLD);
        check("R1", 0);
        tick(1);
        check("R1", tune[0]);
    endtask

    initial begin
        t_reset();
        t_first_note();
        t_pause();
        t_loop();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule